// File: doc/BRIEF.md
# Inter-core mailbox doorbell

The block holds one 32-bit doorbell word per core so that cores can signal each other. A sender raises bits in a target core's word by writing to that core's set alias. The receiver reads its word and acknowledges bits by writing ones to its clear alias. The value of a doorbell word cannot be overwritten directly. It changes only through the set and clear aliases. Each core has an enable bit in its own control word, and the core's interrupt line is high while that enable is on and its doorbell word is non-zero.

The register bus is synchronous and has several independent access ports, one per requester. A write takes effect at the clock edge that accepts it. Read data is registered and appears in the cycle after the request. Each bit of a doorbell word stands for one message number. Receiving software serves the lowest set bit first and clears only that bit.

Top module: `mbx_doorbell`

## Requirements
- R1: A write to byte address 0x40 + 16*c ORs the one-bits of the write data into core c's doorbell word. Zero bits leave the word unchanged.
- R2: A write to byte address 0x80 + 16*c clears the bits of core c's doorbell word that are one in the write data. All other bits are kept.
- R3: A read of 0x80 + 16*c returns core c's doorbell word as it was before that clock edge. A read of the set alias 0x40 + 16*c returns zero. Read data is valid in the cycle after the request and is zero in any cycle that follows no read.
- R4: Bit 0 of the control word at byte address 4*c is core c's interrupt enable. A write loads the enable from write-data bit 0 and ignores the other bits. A read returns the enable in bit 0, with zeros in bits 31..1.
- R5: irq[c] is high exactly when core c's enable is 1 and its doorbell word is non-zero. It follows a write in the cycle after the accepting edge.
- R6: If one port sets and another port clears the same doorbell word in the same cycle, the set wins for every bit named in both. The bits named only in the clear are still cleared.
- R7: If two ports write the same control word in the same cycle, the value from the higher-numbered port is taken.
- R8: A write to any other address is ignored, including unused words inside a 16-byte stride and addresses that are not word aligned. A read of any other address returns zero.
- R9: Reset is synchronous and active high. It clears every doorbell word, every enable, every interrupt and the read data.
- R10: Clearing only the lowest set bit of a multi-bit doorbell word leaves the higher bits pending. The interrupt stays high until the last bit is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | NPORT | Per-port access request |
| bus_we | input | NPORT | Per-port write (1) or read (0) |
| bus_addr | input | NPORT x 8 | Per-port byte address |
| bus_wdata | input | NPORT x 32 | Per-port write data |
| bus_rdata | output | NPORT x 32 | Per-port registered read data |
| irq | output | NCORE | Per-core doorbell interrupt |

## Verification
A sender ringing a doorbell and its receiver acknowledging the same word can fall in the same cycle. The bench provokes this by holding port 0 on a clear alias and port 1 on the matching set alias during a single edge, with masks that share some bits and differ in others. It then reads the word back and compares it with the expected result: the shared bits stay set and the clear-only bits are gone. The same two-port approach drives two conflicting writes to one control word in a single cycle, and the bench judges the outcome from the enable read-back and from irq.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int MBX_AW = 8;
  parameter int MBX_DW = 32;

  typedef logic [MBX_AW-1:0] addr_t;
  typedef logic [MBX_DW-1:0] word_t;

  // Byte address of a per-core register: region base plus index times stride.
  function automatic addr_t slot_addr(input addr_t base, input int idx, input int stride);
    slot_addr = base + addr_t'(idx * stride);
  endfunction

  // Next doorbell value: clear first, then set, so a set overrides a clear.
  function automatic word_t next_word(input word_t cur, input word_t set_m, input word_t clr_m);
    next_word = (cur & ~clr_m) | set_m;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int    NCORE     = 4,
  parameter addr_t CTRL_BASE = 8'h00,
  parameter addr_t SET_BASE  = 8'h40,
  parameter addr_t CLR_BASE  = 8'h80,
  parameter int    STRIDE    = 16,
  parameter int    CSTRIDE   = 4
) (
  input  logic                         en,
  input  logic                         we,
  input  addr_t                        addr,
  input  word_t                        wdata,
  output logic [NCORE-1:0][MBX_DW-1:0] set_m,
  output logic [NCORE-1:0][MBX_DW-1:0] clr_m,
  output logic [NCORE-1:0]             ctl_we,
  output logic [NCORE-1:0]             rd_ctl,
  output logic [NCORE-1:0]             rd_mbx
);
  logic wr, rd;
  assign wr = en & we;
  assign rd = en & ~we;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic hit_set, hit_clr, hit_ctl;
    assign hit_set  = (addr == slot_addr(SET_BASE, c, STRIDE));
    assign hit_clr  = (addr == slot_addr(CLR_BASE, c, STRIDE));
    assign hit_ctl  = (addr == slot_addr(CTRL_BASE, c, CSTRIDE));
    assign set_m[c] = (wr & hit_set) ? wdata : '0;
    assign clr_m[c] = (wr & hit_clr) ? wdata : '0;
    assign ctl_we[c] = wr & hit_ctl;
    assign rd_ctl[c] = rd & hit_ctl;
    assign rd_mbx[c] = rd & hit_clr;
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t set_m,
  input  word_t clr_m,
  input  logic  ctl_we,
  input  logic  ctl_bit,
  output word_t mbox,
  output logic  enable,
  output logic  irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mbox   <= '0;
      enable <= 1'b0;
    end else begin
      mbox <= next_word(mbox, set_m, clr_m);
      if (ctl_we) enable <= ctl_bit;
    end
  end

  assign irq = enable & (|mbox);
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int    NCORE     = 4,
  parameter int    NPORT     = 2,
  parameter addr_t CTRL_BASE = 8'h00,
  parameter addr_t SET_BASE  = 8'h40,
  parameter addr_t CLR_BASE  = 8'h80
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             bus_en,
  input  logic [NPORT-1:0]             bus_we,
  input  logic [NPORT-1:0][MBX_AW-1:0] bus_addr,
  input  logic [NPORT-1:0][MBX_DW-1:0] bus_wdata,
  output logic [NPORT-1:0][MBX_DW-1:0] bus_rdata,
  output logic [NCORE-1:0]             irq
);
  localparam int STRIDE  = 16;
  localparam int CSTRIDE = 4;

  logic [NPORT-1:0][NCORE-1:0][MBX_DW-1:0] p_set, p_clr;
  logic [NPORT-1:0][NCORE-1:0]             p_ctl, p_rd_ctl, p_rd_mbx;
  logic [NPORT-1:0][NCORE-1:0]             p_rd_hit;
  logic [NCORE-1:0][MBX_DW-1:0]            set_or, clr_or, mbox_q;
  logic [NCORE-1:0]                        ctl_we, ctl_bit, en_q;
  logic [NPORT-1:0][MBX_DW-1:0]            rd_val;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_decode #(
      .NCORE(NCORE), .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE),
      .CLR_BASE(CLR_BASE), .STRIDE(STRIDE), .CSTRIDE(CSTRIDE)
    ) u_dec (
      .en(bus_en[p]), .we(bus_we[p]), .addr(bus_addr[p]), .wdata(bus_wdata[p]),
      .set_m(p_set[p]), .clr_m(p_clr[p]), .ctl_we(p_ctl[p]),
      .rd_ctl(p_rd_ctl[p]), .rd_mbx(p_rd_mbx[p])
    );
    assign p_rd_hit[p] = p_rd_ctl[p] | p_rd_mbx[p];
  end

  // Merge all ports per core; later ports override control writes.
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      set_or[c]  = '0;
      clr_or[c]  = '0;
      ctl_we[c]  = 1'b0;
      ctl_bit[c] = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        set_or[c] = set_or[c] | p_set[p][c];
        clr_or[c] = clr_or[c] | p_clr[p][c];
        if (p_ctl[p][c]) begin
          ctl_we[c]  = 1'b1;
          ctl_bit[c] = bus_wdata[p][0];
        end
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_slot
    mbx_slot u_slot (
      .clk(clk), .rst(rst), .set_m(set_or[c]), .clr_m(clr_or[c]),
      .ctl_we(ctl_we[c]), .ctl_bit(ctl_bit[c]),
      .mbox(mbox_q[c]), .enable(en_q[c]), .irq(irq[c])
    );
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rd_val[p] = '0;
      for (int c = 0; c < NCORE; c++) begin
        if (p_rd_ctl[p][c]) rd_val[p] = rd_val[p] | word_t'(en_q[c]);
        if (p_rd_mbx[p][c]) rd_val[p] = rd_val[p] | mbox_q[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_val;
  end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
  import mbx_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NPORT = 2
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NCORE-1:0]                  irq,
  input logic [NCORE-1:0]                  en_q,
  input logic [NCORE-1:0][MBX_DW-1:0]      mbox_q,
  input logic [NCORE-1:0][MBX_DW-1:0]      set_or,
  input logic [NCORE-1:0][MBX_DW-1:0]      clr_or,
  input logic [NPORT-1:0][NCORE-1:0]       p_rd_hit
);
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    // R1 and R6: every bit that is set appears in the next cycle.
    a_r1_set_lands: assert property (@(posedge clk) disable iff (rst)
      (set_or[c] != '0) |=> (($past(set_or[c]) & ~mbox_q[c]) == '0));
    // R2: clear-only bits are gone in the next cycle.
    a_r2_clear_lands: assert property (@(posedge clk) disable iff (rst)
      ((clr_or[c] & ~set_or[c]) != '0) |=> ((mbox_q[c] & $past(clr_or[c] & ~set_or[c])) == '0));
    // R10: pending bits are lost only through a clear.
    a_r10_no_loss: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((($past(mbox_q[c]) & ~$past(clr_or[c])) & ~mbox_q[c]) == '0));
    // R1: new bits appear only through a set.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((mbox_q[c] & ~$past(mbox_q[c]) & ~$past(set_or[c])) == '0));
    // R5: the interrupt needs the enable and pending work.
    a_r5_irq_qualified: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> (en_q[c] && (mbox_q[c] != '0)));
    a_r5_irq_raised: assert property (@(posedge clk) disable iff (rst)
      (en_q[c] && (mbox_q[c] != '0)) |-> irq[c]);
    // R9: reset clears the state.
    a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> ((mbox_q[c] == '0) && !en_q[c] && !irq[c]));
  end
  for (genvar p = 0; p < NPORT; p++) begin : g_p
    // R8: one read selects at most one register.
    a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
      $onehot0(p_rd_hit[p]));
  end
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.NCORE(NCORE), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .en_q(en_q), .mbox_q(mbox_q),
  .set_or(set_or), .clr_or(clr_or), .p_rd_hit(p_rd_hit)
);

// File: tb/mbx_doorbell_test.sv
module mbx_doorbell_test;
  localparam int NC = 4;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]        bus_en = '0;
  logic [NP-1:0]        bus_we = '0;
  logic [NP-1:0][7:0]   bus_addr = '0;
  logic [NP-1:0][31:0]  bus_wdata = '0;
  logic [NP-1:0][31:0]  bus_rdata;
  logic [NC-1:0]        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mbx_doorbell uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Vector: we, addr, wdata, expected rdata (reads), expected irq.
  typedef logic [76:0] vec_t;
  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    {1'b1, 8'h00, 32'h0000_0001, 32'h0, 4'b0000}, // R4 enable core0
    {1'b1, 8'h40, 32'h0000_0005, 32'h0, 4'b0001}, // R1 ring core0
    {1'b0, 8'h80, 32'h0,         32'h0000_0005, 4'b0001}, // R3
    {1'b1, 8'h40, 32'h0000_0008, 32'h0, 4'b0001}, // R1 OR in
    {1'b0, 8'h80, 32'h0,         32'h0000_000D, 4'b0001}, // R1
    {1'b1, 8'h80, 32'h0000_0001, 32'h0, 4'b0001}, // R2
    {1'b0, 8'h80, 32'h0,         32'h0000_000C, 4'b0001}, // R2
    {1'b0, 8'h40, 32'h0,         32'h0,         4'b0001}, // R3 set alias reads 0
    {1'b0, 8'h00, 32'h0,         32'h0000_0001, 4'b0001}, // R4 readback
    {1'b1, 8'h50, 32'h8000_0000, 32'h0, 4'b0001}, // R5 core1 pending, disabled
    {1'b0, 8'h90, 32'h0,         32'h8000_0000, 4'b0001}, // R3
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'b0011}, // R4 R5
    {1'b0, 8'h04, 32'h0,         32'h0000_0001, 4'b0011}, // R4 upper bits zero
    {1'b1, 8'h80, 32'h0000_000C, 32'h0, 4'b0010}, // R2 R5
    {1'b1, 8'h44, 32'h0000_00FF, 32'h0, 4'b0010}, // R8 gap in stride
    {1'b0, 8'h44, 32'h0,         32'h0,         4'b0010}, // R8
    {1'b1, 8'hC0, 32'h0000_00FF, 32'h0, 4'b0010}, // R8 unmapped
    {1'b1, 8'h41, 32'h0000_00FF, 32'h0, 4'b0010}, // R8 unaligned
    {1'b0, 8'h80, 32'h0,         32'h0,         4'b0010}, // R8 core0 untouched
    {1'b0, 8'hC0, 32'h0,         32'h0,         4'b0010}, // R8
    {1'b1, 8'h04, 32'h0000_0002, 32'h0, 4'b0000}, // R4 bit0=0 disables
    {1'b0, 8'h90, 32'h0,         32'h8000_0000, 4'b0000}  // R5 word kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access on one port; sampled at the next falling edge.
  task automatic access(input int p, input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en[p] = 1'b1; bus_we[p] = we; bus_addr[p] = a; bus_wdata[p] = d;
    @(negedge clk);
    bus_en = '0; bus_we = '0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    access(0, 1'b0, a, 32'h0);
    check(req, bus_rdata[0], exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 irq after reset", 32'(irq), 32'h0);
    read_chk("R9 doorbell after reset", 8'h80, 32'h0);
    read_chk("R9 enable after reset", 8'h00, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(0, TBL[i][76], TBL[i][75:68], TBL[i][67:36]);
      if (!TBL[i][76]) check($sformatf("vector %0d rdata", i), bus_rdata[0], TBL[i][35:4]);
      else             check($sformatf("vector %0d write rdata", i), bus_rdata[0], 32'h0); // R3
      check($sformatf("vector %0d irq R5", i), 32'(irq), 32'(TBL[i][3:0]));
    end

    // R6: set and clear of core2 in one cycle.
    access(0, 1'b1, 8'h60, 32'h0000_0003);
    access(0, 1'b1, 8'h08, 32'h1);
    check("R5 core2 irq", 32'(irq[2]), 32'h1);
    @(negedge clk);
    bus_en = 2'b11; bus_we = 2'b11;
    bus_addr[0] = 8'hA0; bus_wdata[0] = 32'h0000_0013;
    bus_addr[1] = 8'h60; bus_wdata[1] = 32'h0000_0011;
    @(negedge clk);
    bus_en = '0; bus_we = '0;
    read_chk("R6 set wins over clear", 8'hA0, 32'h0000_0011);

    // R7: conflicting control writes, higher port wins.
    @(negedge clk);
    bus_en = 2'b11; bus_we = 2'b11;
    bus_addr[0] = 8'h08; bus_wdata[0] = 32'h1;
    bus_addr[1] = 8'h08; bus_wdata[1] = 32'h0;
    @(negedge clk);
    bus_en = '0; bus_we = '0;
    check("R7 irq core2 disabled", 32'(irq[2]), 32'h0);
    read_chk("R7 enable core2", 8'h08, 32'h0);
    @(negedge clk);
    bus_en = 2'b11; bus_we = 2'b11;
    bus_addr[0] = 8'h08; bus_wdata[0] = 32'h0;
    bus_addr[1] = 8'h08; bus_wdata[1] = 32'h1;
    @(negedge clk);
    bus_en = '0; bus_we = '0;
    read_chk("R7 enable core2 from port1", 8'h08, 32'h1);

    // R10: lowest-bit-first drain of core3, using port 1 to ring.
    access(1, 1'b1, 8'h70, 32'h8000_0124);
    access(0, 1'b1, 8'h0C, 32'h1);
    begin
      logic [31:0] model = 32'h8000_0124;
      for (int k = 0; k < 4; k++) begin
        int low = 0;
        for (int b = 31; b >= 0; b--) if (model[b]) low = b;
        read_chk("R10 pending word", 8'hB0, model);
        check("R10 irq while pending", 32'(irq[3]), 32'h1);
        access(0, 1'b1, 8'hB0, 32'h1 << low);
        model[low] = 1'b0;
      end
      read_chk("R10 drained", 8'hB0, 32'h0);
      check("R10 irq after drain", 32'(irq[3]), 32'h0);
    end

    // R9: reset in mid-run.
    access(1, 1'b1, 8'h70, 32'h5);
    check("R5 core3 irq before reset", 32'(irq[3]), 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 irq after mid reset", 32'(irq), 32'h0);
    read_chk("R9 core3 word", 8'hB0, 32'h0);
    read_chk("R9 core1 word", 8'h90, 32'h0);
    read_chk("R9 core3 enable", 8'h0C, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule